// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block runs through a ring of transmit buffer descriptors kept in a local synchronous memory. A start pulse sets it going. It reads each descriptor and looks at the ownership bit. If hardware owns the descriptor, the block passes the buffer address, length, end-of-frame marker and pad request to a data mover over a valid/ready handshake. It then waits for the mover to report completion. After that it writes the descriptor back with ownership returned to software, and with an error mark when the mover reported a fault. The next descriptor is either the following slot or, when the descriptor carries a wrap flag, the slot named by a base input.

If the walk reaches a descriptor that software still owns, the block parks on that slot until the next start pulse. Serviced buffers that request notification set sticky buffer or frame events. An interrupt line reports these events through per-event enables. An error from the mover closes the frame in progress: the rest of that frame's descriptors are returned to software, marked as failed, and are not handed to the mover.

Top module: `tx_ring_walker`

Each descriptor is one 64-bit memory word. Bits 63:48 hold the flag halfword, bits 47:32 the byte length, and bits 31:0 the buffer address. Flag bits, by word bit: 63 owned-by-hardware, 62 pad, 61 wrap, 60 notify, 59 end-of-frame, 57 error (written by hardware). All other flag bits are zero.

## Requirements
- R1: After reset, mv_valid, mem_rd, mem_wr, buf_ev, frm_ev and irq are all 0, and no memory access happens until a start pulse arrives.
- R2: The first start pulse after reset fetches the descriptor at ring_base. Each owned descriptor (bit 63 = 1) is offered to the mover, with mv_addr = bits 31:0, mv_len = bits 47:32 and mv_last = bit 59, in ring order.
- R3: A fetched descriptor with bit 63 = 0 is not offered and not written. The walk stops, and the next start pulse fetches that same slot again.
- R4: After mv_done without mv_err, the descriptor is written back to its own slot with bit 63 cleared, bit 57 clear, and every other bit unchanged.
- R5: After servicing a descriptor with bit 61 = 1, the next fetch is at ring_base. Otherwise it is at the following slot.
- R6: mv_pad for every buffer of a frame equals bit 62 of the first descriptor of that frame.
- R7: A serviced descriptor with bit 60 = 1 sets frm_ev if bit 59 = 1, and sets buf_ev otherwise. With bit 60 = 0, no event is set.
- R8: buf_ev and frm_ev stay set until the matching clear input is pulsed. irq is high exactly when (buf_ev and buf_en) or (frm_ev and frm_en).
- R9: mv_done with mv_err writes the descriptor back with bit 63 cleared and bit 57 set, and treats it as the frame end for events (frm_ev if bit 60 = 1). The following descriptors up to and including the next one with bit 59 = 1 are written back the same way without being offered, and they set no events.
- R10: While mv_valid is high and mv_ready is low, mv_valid and all offered fields hold steady, and no memory access happens during the offer.
- R11: A start pulse that arrives while the walk is running has no effect on the order of offered buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume walking |
| ring_base | input | AW | Slot index of the first descriptor in the ring |
| mem_rd | output | 1 | Descriptor read strobe, data returns next cycle |
| mem_wr | output | 1 | Descriptor write strobe |
| mem_addr | output | AW | Descriptor slot index |
| mem_wdata | output | 64 | Written-back descriptor |
| mem_rdata | input | 64 | Read descriptor, valid the cycle after mem_rd |
| mv_valid | output | 1 | Buffer offer to the mover |
| mv_ready | input | 1 | Mover accepts the offer |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | 16 | Buffer byte length |
| mv_last | output | 1 | Buffer ends a frame |
| mv_pad | output | 1 | Pad request of the current frame |
| mv_done | input | 1 | Mover finished the accepted buffer |
| mv_err | input | 1 | Qualifies mv_done as a failure |
| buf_en | input | 1 | Enable buffer event onto irq |
| frm_en | input | 1 | Enable frame event onto irq |
| clr_buf | input | 1 | Clear buffer event |
| clr_frm | input | 1 | Clear frame event |
| buf_ev | output | 1 | Sticky buffer event |
| frm_ev | output | 1 | Sticky frame event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved mover and memory. mv_done is pulsed only after an offer has been accepted, and only once per accepted buffer. Read data arrives exactly one cycle after the strobe. Software leaves a descriptor alone while it is owned by hardware. The bench keeps to these rules: its memory model answers reads with one cycle of latency, and its mover gives one completion, a few cycles after each accept. Descriptors are rewritten only after the block has parked on a slot it does not own, and never on a slot still waiting to be fetched in a live walk.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int AW = 4,
  parameter int LW = 16,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ring_base,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  output logic          mv_valid,
  input  logic          mv_ready,
  output logic [PW-1:0] mv_addr,
  output logic [LW-1:0] mv_len,
  output logic          mv_last,
  output logic          mv_pad,
  input  logic          mv_done,
  input  logic          mv_err,
  input  logic          buf_en,
  input  logic          frm_en,
  input  logic          clr_buf,
  input  logic          clr_frm,
  output logic          buf_ev,
  output logic          frm_ev,
  output logic          irq
);
  localparam int DW    = 64;
  localparam int B_OWN = DW - 1;
  localparam int B_PAD = DW - 2;
  localparam int B_WRP = DW - 3;
  localparam int B_NTF = DW - 4;
  localparam int B_EOF = DW - 5;
  localparam int B_ERR = DW - 7;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_OFFER, S_BUSY, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] cur;
  logic [DW-1:0] desc;
  logic          need_base, first, fpad, flush, err_q;
  logic          buf_set, frm_set;

  wire d_wrap = desc[B_WRP];
  wire d_ntf  = desc[B_NTF];
  wire d_eof  = desc[B_EOF];

  assign mem_rd    = (st == S_FETCH);
  assign mem_wr    = (st == S_WB);
  assign mem_addr  = cur;
  assign mem_wdata = {1'b0, desc[B_OWN-1:B_ERR+1], err_q, desc[B_ERR-1:0]};

  assign mv_valid = (st == S_OFFER);
  assign mv_addr  = desc[PW-1:0];
  assign mv_len   = desc[PW+LW-1:PW];
  assign mv_last  = d_eof;
  assign mv_pad   = fpad;

  assign buf_set = mem_wr && d_ntf && !flush && !d_eof && !err_q;
  assign frm_set = mem_wr && d_ntf && !flush && (d_eof || err_q);
  assign irq     = (buf_ev && buf_en) || (frm_ev && frm_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur       <= '0;
      desc      <= '0;
      need_base <= 1'b1;
      first     <= 1'b1;
      fpad      <= 1'b0;
      flush     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (need_base) cur <= ring_base;
          need_base <= 1'b0;
          st        <= S_FETCH;
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          desc  <= mem_rdata;
          err_q <= flush;
          if (!mem_rdata[B_OWN]) begin
            st <= S_IDLE;
          end else if (flush) begin
            st <= S_WB;
          end else begin
            if (first) fpad <= mem_rdata[B_PAD];
            st <= S_OFFER;
          end
        end
        S_OFFER: if (mv_ready) st <= S_BUSY;
        S_BUSY: if (mv_done) begin
          err_q <= mv_err;
          st    <= S_WB;
        end
        S_WB: begin
          cur   <= d_wrap ? ring_base : cur + 1'b1;
          first <= d_eof;
          flush <= !d_eof && (flush || err_q);
          st    <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_ev <= 1'b0;
      frm_ev <= 1'b0;
    end else begin
      buf_ev <= (buf_ev && !clr_buf) || buf_set;
      frm_ev <= (frm_ev && !clr_frm) || frm_set;
    end
  end
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk #(
  parameter int AW = 4,
  parameter int LW = 16,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [63:0]   mem_wdata,
  input logic          mv_valid,
  input logic          mv_ready,
  input logic [PW-1:0] mv_addr,
  input logic [LW-1:0] mv_len,
  input logic          mv_last,
  input logic          mv_pad,
  input logic          clr_buf,
  input logic          clr_frm,
  input logic          buf_ev,
  input logic          frm_ev
);
  a_r10_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_addr) && $stable(mv_len)
                              && $stable(mv_last) && $stable(mv_pad));

  a_r10_quiet_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> !mem_rd && !mem_wr);

  a_r4_owner_back: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_wdata[63]);

  a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r8_buf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ev && !clr_buf |=> buf_ev);

  a_r8_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ev && !clr_frm |=> frm_ev);

  a_r1_no_event_unread: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ev) || $rose(frm_ev) |-> $past(mem_wr));
endmodule

bind tx_ring_walker tx_ring_walker_chk #(.AW(AW), .LW(LW), .PW(PW)) chk_i (.*);

// File: tb/tx_ring_walker_tb_top.sv
`timescale 1ns/1ps
module tx_ring_walker_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [AW-1:0] ring_base;
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic mv_valid, mv_ready, mv_last, mv_pad, mv_done, mv_err;
  logic [31:0] mv_addr;
  logic [15:0] mv_len;
  logic buf_en, frm_en, clr_buf, clr_frm, buf_ev, frm_ev, irq;

  always #2 clk = ~clk;

  tx_ring_walker dut_i (.*);

  logic [63:0] mem [16];
  int rdcnt;
  logic [AW-1:0] last_rd;
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      last_rd   <= mem_addr;
      rdcnt     <= rdcnt + 1;
    end
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  int errors = 0, checks = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [50:0] expq [$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit own, bit pad, bit wrp, bit ntf, bit eof,
                                     logic [15:0] len, logic [31:0] a);
    return {own, pad, wrp, ntf, eof, 11'b0, len, a};
  endfunction

  function automatic logic [63:0] back(logic [63:0] d, bit e);
    d[63] = 1'b0;
    d[57] = e;
    return d;
  endfunction

  task automatic expect_buf(logic [31:0] a, logic [15:0] l, bit last, bit pad);
    expq.push_back({a, l, last, pad, 1'b0});
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // mover model and scoreboard monitor
  initial begin
    int d;
    logic [31:0] a;
    logic [50:0] e;
    d = 0;
    mv_ready = 1'b0; mv_done = 1'b0; mv_err = 1'b0;
    forever begin
      @(negedge clk);
      if (mv_valid) begin
        a = mv_addr;
        for (int k = 0; k < d; k++) begin
          @(negedge clk);
          chk("R10 offer held", {63'b0, mv_valid && mv_addr == a}, 64'd1);
        end
        d = (d + 1) % 3;
        if (expq.size() == 0) begin
          chk("R2 unexpected offer", {32'b0, mv_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          e = expq.pop_front();
          chk("R2 offer addr/len/last", {15'b0, mv_addr, mv_len, mv_last}, {15'b0, e[50:2]});
          chk("R6 pad of frame", {63'b0, mv_pad}, {63'b0, e[1]});
        end
        mv_ready = 1'b1;
        @(negedge clk); mv_ready = 1'b0;
        repeat (2) @(negedge clk);
        mv_err = (a == err_addr); mv_done = 1'b1;
        @(negedge clk); mv_done = 1'b0; mv_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d2, d3, d4, d5;
    rst_n = 1'b0; start = 1'b0; ring_base = 4'd2;
    buf_en = 1'b0; frm_en = 1'b0; clr_buf = 1'b0; clr_frm = 1'b0;
    rdcnt = 0; last_rd = '0; mem_rdata = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset quiet", {58'b0, mv_valid, mem_rd, mem_wr, buf_ev, frm_ev, irq}, 64'd0);
    chk("R1 no read before start", rdcnt, 0);

    // scenario 1: three-buffer frame, stop at unowned slot 5
    d2 = mk(1, 1, 0, 0, 0, 16'd10, 32'hA000_0200);
    d3 = mk(1, 0, 0, 1, 0, 16'd20, 32'hA000_0300);
    d4 = mk(1, 0, 0, 1, 1, 16'd30, 32'hA000_0400);
    mem[2] = d2; mem[3] = d3; mem[4] = d4;
    expect_buf(32'hA000_0200, 16'd10, 0, 1);
    expect_buf(32'hA000_0300, 16'd20, 0, 1);
    expect_buf(32'hA000_0400, 16'd30, 1, 1);
    pulse_start();
    repeat (12) @(negedge clk);
    pulse_start(); // R11: ignored while walking
    repeat (100) @(negedge clk);
    chk("R2 all offers seen", expq.size(), 0);
    chk("R4 writeback slot 2", mem[2], back(d2, 0));
    chk("R4 writeback slot 3", mem[3], back(d3, 0));
    chk("R4 writeback slot 4", mem[4], back(d4, 0));
    chk("R3 unowned slot untouched", mem[5], 64'd0);
    chk("R7 buffer and frame events", {62'b0, buf_ev, frm_ev}, 64'd3);
    chk("R8 irq masked", {63'b0, irq}, 64'd0);

    // R3: restart refetches the same slot
    rdcnt = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R3 single refetch", rdcnt, 1);
    chk("R3 refetch slot", {60'b0, last_rd}, 64'd5);

    // R8: enables and clears
    buf_en = 1'b1; @(negedge clk);
    chk("R8 irq from buffer event", {63'b0, irq}, 64'd1);
    clr_buf = 1'b1; @(negedge clk); clr_buf = 1'b0; @(negedge clk);
    chk("R8 buffer event cleared", {62'b0, buf_ev, irq}, 64'd0);
    frm_en = 1'b1; @(negedge clk);
    chk("R8 irq from frame event", {63'b0, irq}, 64'd1);
    clr_frm = 1'b1; @(negedge clk); clr_frm = 1'b0; @(negedge clk);
    chk("R8 frame event cleared", {62'b0, frm_ev, irq}, 64'd0);

    // scenario 2: wrap from slot 5 back to ring_base
    d5 = mk(1, 0, 1, 0, 1, 16'd40, 32'hB000_0500);
    d2 = mk(1, 0, 0, 0, 1, 16'd50, 32'hB000_0200);
    mem[5] = d5; mem[2] = d2;
    expect_buf(32'hB000_0500, 16'd40, 1, 0);
    expect_buf(32'hB000_0200, 16'd50, 1, 0);
    pulse_start();
    repeat (80) @(negedge clk);
    chk("R5 wrapped offers seen", expq.size(), 0);
    chk("R5 stop slot after wrap", {60'b0, last_rd}, 64'd3);
    chk("R4 writeback wrap slot", mem[5], back(d5, 0));
    chk("R7 no event without notify", {62'b0, buf_ev, frm_ev}, 64'd0);

    // scenario 3: pad follows first buffer of frame
    d3 = mk(1, 1, 0, 1, 0, 16'd60, 32'hC000_0300);
    d4 = mk(1, 0, 0, 0, 1, 16'd70, 32'hC000_0400);
    mem[3] = d3; mem[4] = d4;
    expect_buf(32'hC000_0300, 16'd60, 0, 1);
    expect_buf(32'hC000_0400, 16'd70, 1, 1);
    pulse_start();
    repeat (80) @(negedge clk);
    chk("R6 pad frame offers seen", expq.size(), 0);
    chk("R7 buffer event only", {62'b0, buf_ev, frm_ev}, 64'd2);
    clr_buf = 1'b1; @(negedge clk); clr_buf = 1'b0;

    // scenario 4: mover error closes the frame
    d5 = mk(1, 0, 1, 1, 0, 16'd80, 32'hE000_0500);
    d2 = mk(1, 0, 0, 1, 0, 16'd90, 32'hE000_0200);
    d3 = mk(1, 0, 0, 1, 1, 16'd100, 32'hE000_0300);
    d4 = mk(1, 1, 0, 0, 1, 16'd110, 32'hE000_0400);
    mem[5] = d5; mem[2] = d2; mem[3] = d3; mem[4] = d4;
    err_addr = 32'hE000_0500;
    expect_buf(32'hE000_0500, 16'd80, 0, 0);
    expect_buf(32'hE000_0400, 16'd110, 1, 1);
    pulse_start();
    repeat (100) @(negedge clk);
    chk("R9 flushed buffers not offered", expq.size(), 0);
    chk("R9 errored slot", mem[5], back(d5, 1));
    chk("R9 flushed slot 2", mem[2], back(d2, 1));
    chk("R9 flushed last slot 3", mem[3], back(d3, 1));
    chk("R9 next frame clean", mem[4], back(d4, 0));
    chk("R9 frame event only", {62'b0, buf_ev, frm_ev}, 64'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule